// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

The block joins two 8-line interrupt controllers, a primary for lines 0 to 7 and a secondary for lines 8 to 15, behind one byte-wide register bus. Each controller keeps a request register, an in-service register, a mask register and a per-line edge/level control register. Request bits are set and cleared by per-line strobes from the interrupt sources. A combinational scan over all sixteen lines chooses the lowest-numbered pending line. The block presents that line, its vector and a request flag to the processor side.

The processor acknowledges a line by naming it. The controller owning that line then marks it in service and, for edge lines, drops its request. Software finishes the interrupt with an end-of-interrupt command on the command port. Each controller must first be brought up with an initialization word sequence written to its command and data ports. Only after that do data-port writes load the mask.

Bus addresses are 0 for the primary command port, 1 for the primary data port, 2 for the secondary command port, 3 for the secondary data port, 4 for the primary edge/level port and 5 for the secondary edge/level port. Other addresses read as 0x00 and ignore writes. The secondary's pending lines reach the processor only through primary line 2.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset the request, in-service, mask and edge/level registers are zero, every port reads 0x00, `int_req` is low and `cmd_err` is low. Data-port writes are ignored until initialization has started.
- R2: A command-port write with bit 4 set is initialization word 1. It clears the mask and the in-service register. Its bit 0 means a fourth word follows, and its bit 1 means single mode with no third word. The next data-port writes are taken in order as the vector base (bits 7:3), the third word (unless single mode), and the fourth word (if requested). After that, data-port writes load the mask. A data-port read always returns the mask.
- R3: A command-port write with bit 4 clear, bit 3 set and bit 1 set loads the read select from bits 1:0. With the read select at 2'b10 the command port reads the request register. With 2'b11 it reads the in-service register. With any other value it reads 0x00. Such a write with bit 1 clear leaves the read select unchanged.
- R4: A line is pending when its request bit is set and its mask bit is clear. Secondary lines also require primary mask bit 2 to be clear. `int_req` is high exactly when some line is pending, and `int_line` is the lowest-numbered pending line.
- R5: `int_vec` equals the owning controller's base ORed with the line number modulo 8.
- R6: An acknowledge of a pending line sets its in-service bit in the next cycle. It clears the line's request bit when the edge/level bit is 0 (edge).
- R7: A request bit whose edge/level bit is 1 (level) stays set through an acknowledge.
- R8: An acknowledge naming a line that is not pending in its own controller changes no register.
- R9: A command-port write with bits 4 and 3 clear is a command word whose bits 7:5 are {R, SL, EOI}. The value 3'b001 clears the lowest set in-service bit. The value 3'b011 clears the in-service bit numbered by bits 2:0.
- R10: Command words with bits 7:5 equal to 3'b110 (set priority) or 3'b010 (no-op) change nothing. Every other value not named in R9 sets the sticky `cmd_err` output.
- R11: Writes to an edge/level port store the data ANDed with a writable-bit mask. The mask is 0xF8 for the primary and 0xDE for the secondary. The port reads back the stored value.
- R12: `line_raise[i]` sets request bit i and `line_lower[i]` clears it. When both are asserted in the same cycle, the raise wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address (0..5) |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| line_raise | input | 16 | Per-line request set strobes |
| line_lower | input | 16 | Per-line request clear strobes |
| int_req | output | 1 | Some line is pending |
| int_line | output | 4 | Lowest-numbered pending line |
| int_vec | output | 8 | Vector of `int_line` |
| ack | input | 1 | Acknowledge strobe |
| ack_line | input | 4 | Line being acknowledged |
| cmd_err | output | 1 | Sticky unsupported-command flag |

## Verification
A corrupted request or mask bit shows up on `int_req`, `int_line` and `int_vec` in the same cycle, because the scan is combinational. A wrong in-service update becomes visible one cycle after an acknowledge or end-of-interrupt, through a command-port read with the read select at 2'b11. A wrong initialization state shows up as a mask that does not read back, or as a wrong vector base on the next pending line. The sweeps therefore raise every single line, every pair of lines and every masked line, and read back both the outputs and the registers after each step.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the cascaded interrupt controller.
// Assumes byte-wide registers and eight lines per controller.
package irq_pkg;
    localparam int DW    = 8;
    localparam int LINES = 8;

    // Initialization sequencer states of one controller.
    typedef enum logic [2:0] {
        ST_WORD1 = 3'd0,
        ST_WORD2 = 3'd1,
        ST_WORD3 = 3'd2,
        ST_WORD4 = 3'd3,
        ST_READY = 3'd4
    } init_st_t;

    // Isolate the lowest set bit of a byte as a one-hot value.
    function automatic logic [DW-1:0] lowest_onehot(input logic [DW-1:0] v);
        return v & (~v + 1'b1);
    endfunction
endpackage

// File: rtl/irq_prio_scan.sv
// Priority scan: reports whether any request bit is set and the index of
// the lowest-numbered one. Purely combinational.
module irq_prio_scan #(
    parameter int N = 16
) (
    input  logic [N-1:0]         req,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Walk from the top so that the lowest set index is written last.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_unit.sv
// One 8-line interrupt controller: request, in-service, mask and
// edge/level registers, the initialization sequencer and the command decoder.
// Assumes each write strobe lasts one cycle and ack_idx is stable with ack_req.
module irq_unit
    import irq_pkg::*;
#(
    parameter logic [DW-1:0] CTL_WMASK = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic                     data_wr,
    input  logic                     ctl_wr,
    input  logic [DW-1:0]            wdata,
    input  logic [LINES-1:0]         raise,
    input  logic [LINES-1:0]         lower,
    input  logic                     ack_req,
    input  logic [$clog2(LINES)-1:0] ack_idx,
    output logic [LINES-1:0]         irr,
    output logic [LINES-1:0]         isr,
    output logic [LINES-1:0]         imr,
    output logic [LINES-1:0]         ctl,
    output logic [LINES-1:0]         pend,
    output logic [DW-1:0]            base,
    output logic [1:0]               rsel,
    output logic                     err
);
    localparam int IW = $clog2(LINES);

    init_st_t         st;
    logic             need_w4, single;
    logic             word1, ocw3, ocw2, ack_ok, bad_cmd;
    logic [LINES-1:0] ack_vec, eoi_clr, irr_n, isr_n;

    // Decode the command-port write and the acknowledge for this cycle.
    always_comb begin
        word1   = cmd_wr && wdata[4];
        ocw3    = cmd_wr && !wdata[4] && wdata[3];
        ocw2    = cmd_wr && !wdata[4] && !wdata[3];
        pend    = irr & ~imr;
        ack_ok  = ack_req && pend[ack_idx];
        ack_vec = ack_ok ? (LINES'(1) << ack_idx) : '0;
        eoi_clr = '0;
        bad_cmd = 1'b0;
        if (ocw2) begin
            case (wdata[7:5])
                3'b001:         eoi_clr = lowest_onehot(isr);
                3'b011:         eoi_clr = LINES'(1) << wdata[IW-1:0];
                3'b110, 3'b010: eoi_clr = '0;
                default:        bad_cmd = 1'b1;
            endcase
        end
        isr_n = word1 ? '0 : ((isr | ack_vec) & ~eoi_clr);
        irr_n = (irr & ~lower & ~(ack_vec & ~ctl)) | raise;
    end

    // Register updates: requests, in-service, sequencer, mask, control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WORD1;
            irr     <= '0;
            isr     <= '0;
            imr     <= '0;
            ctl     <= '0;
            base    <= '0;
            rsel    <= 2'b00;
            need_w4 <= 1'b0;
            single  <= 1'b0;
            err     <= 1'b0;
        end else begin
            irr <= irr_n;
            isr <= isr_n;
            if (bad_cmd) err <= 1'b1;
            if (ctl_wr) ctl <= wdata & CTL_WMASK;
            if (ocw3 && wdata[1]) rsel <= wdata[1:0];
            if (word1) begin
                st      <= ST_WORD2;
                need_w4 <= wdata[0];
                single  <= wdata[1];
                imr     <= '0;
            end else if (data_wr) begin
                case (st)
                    ST_WORD2: begin
                        base <= {wdata[DW-1:IW], {IW{1'b0}}};
                        st   <= single ? (need_w4 ? ST_WORD4 : ST_READY) : ST_WORD3;
                    end
                    ST_WORD3: st  <= need_w4 ? ST_WORD4 : ST_READY;
                    ST_WORD4: st  <= ST_READY;
                    ST_READY: imr <= wdata;
                    default:  st  <= st;
                endcase
            end
        end
    end

    // R6
    edge_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !ctl[ack_idx] && !raise[ack_idx]) |=> !irr[$past(ack_idx)]);

    // R7
    level_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && ctl[ack_idx] && !lower[ack_idx]) |=> irr[$past(ack_idx)]);

    // R8
    stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !pend[ack_idx] && !cmd_wr && raise == '0 && lower == '0)
        |=> ($stable(isr) && $stable(irr)));

    // R6
    isr_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr & ~$past(isr))) |-> $past(ack_ok));

    // R2
    mask_load_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(imr) |-> ($past(word1) || $past(data_wr && st == ST_READY)));
endmodule

// File: rtl/dual_irq_ctrl.sv
// Cascaded pair of 8-line interrupt controllers behind a byte-wide bus.
// Lines 0..7 belong to the primary, 8..15 to the secondary; the secondary
// reaches the processor through primary line CASCADE_LINE.
// Assumes bus_wr and ack are single-cycle strobes.
module dual_irq_ctrl
    import irq_pkg::*;
#(
    parameter logic [DW-1:0] PRI_CTL_WMASK = 8'hF8,
    parameter logic [DW-1:0] SEC_CTL_WMASK = 8'hDE,
    parameter int            CASCADE_LINE  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [15:0]   line_raise,
    input  logic [15:0]   line_lower,
    output logic          int_req,
    output logic [3:0]    int_line,
    output logic [DW-1:0] int_vec,
    input  logic          ack,
    input  logic [3:0]    ack_line,
    output logic          cmd_err
);
    localparam int UNITS = 2;
    localparam int TOTAL = UNITS * LINES;
    localparam int IW    = $clog2(LINES);

    logic [UNITS-1:0][LINES-1:0] irr, isr, imr, ctl, pend;
    logic [UNITS-1:0][DW-1:0]    base;
    logic [UNITS-1:0][1:0]       rsel;
    logic [UNITS-1:0]            err, cmd_wr, data_wr, ctl_wr, ack_req;
    logic [TOTAL-1:0]            pend_all;
    logic                        scan_hit;
    logic [$clog2(TOTAL)-1:0]    scan_idx;

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        localparam logic [DW-1:0] WMASK = (g == 0) ? PRI_CTL_WMASK : SEC_CTL_WMASK;
        // Route bus strobes and the acknowledge to this controller.
        assign cmd_wr[g]  = bus_wr && (bus_addr == 3'(2 * g));
        assign data_wr[g] = bus_wr && (bus_addr == 3'(2 * g + 1));
        assign ctl_wr[g]  = bus_wr && (bus_addr == 3'(4 + g));
        assign ack_req[g] = ack && (ack_line[3] == 1'(g));

        irq_unit #(.CTL_WMASK(WMASK)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_wr  (cmd_wr[g]),
            .data_wr (data_wr[g]),
            .ctl_wr  (ctl_wr[g]),
            .wdata   (bus_wdata),
            .raise   (line_raise[g*LINES +: LINES]),
            .lower   (line_lower[g*LINES +: LINES]),
            .ack_req (ack_req[g]),
            .ack_idx (ack_line[IW-1:0]),
            .irr     (irr[g]),
            .isr     (isr[g]),
            .imr     (imr[g]),
            .ctl     (ctl[g]),
            .pend    (pend[g]),
            .base    (base[g]),
            .rsel    (rsel[g]),
            .err     (err[g])
        );
    end

    // Secondary lines are visible only while the cascade line is unmasked.
    assign pend_all = {pend[1] & {LINES{~imr[0][CASCADE_LINE]}}, pend[0]};

    irq_prio_scan #(.N(TOTAL)) u_scan (
        .req (pend_all),
        .hit (scan_hit),
        .idx (scan_idx)
    );

    // Present the winning line and its vector.
    always_comb begin
        int_req  = scan_hit;
        int_line = scan_idx;
        int_vec  = base[scan_idx[IW]] | {{(DW-IW){1'b0}}, scan_idx[IW-1:0]};
        cmd_err  = |err;
    end

    // Read multiplexer over the six register ports.
    always_comb begin
        case (bus_addr)
            3'd0, 3'd2: begin
                case (rsel[bus_addr[1]])
                    2'b10:   bus_rdata = irr[bus_addr[1]];
                    2'b11:   bus_rdata = isr[bus_addr[1]];
                    default: bus_rdata = '0;
                endcase
            end
            3'd1, 3'd3: bus_rdata = imr[bus_addr[1]];
            3'd4, 3'd5: bus_rdata = ctl[bus_addr[0]];
            default:    bus_rdata = '0;
        endcase
    end

    // R4
    no_req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr[0] & ~imr[0]) == '0 && ((irr[1] & ~imr[1]) == '0 || imr[0][CASCADE_LINE]))
        |-> !int_req);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_err) |-> cmd_err);
endmodule

// File: tb/dual_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dual_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] line_raise = '0;
    logic [15:0] line_lower = '0;
    logic        int_req;
    logic [3:0]  int_line;
    logic [7:0]  int_vec;
    logic        ack = 1'b0;
    logic [3:0]  ack_line = '0;
    logic        cmd_err;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    dual_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_raise(line_raise),
        .line_lower(line_lower), .int_req(int_req), .int_line(int_line),
        .int_vec(int_vec), .ack(ack), .ack_line(ack_line), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; #1 v = bus_rdata;
    endtask

    task automatic lines(input logic [15:0] r, input logic [15:0] lo);
        @(negedge clk); line_raise = r; line_lower = lo;
        @(negedge clk); line_raise = '0; line_lower = '0; #1;
    endtask

    task automatic do_ack(input int l);
        @(negedge clk); ack = 1'b1; ack_line = 4'(l);
        @(negedge clk); ack = 1'b0; #1;
    endtask

    function automatic logic [7:0] vexp(input int l);
        return (l < 8) ? 8'(8'h40 + l) : 8'(8'h70 + l - 8);
    endfunction

    function automatic logic [2:0] cmd_of(input int l);
        return (l < 8) ? 3'd0 : 3'd2;
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got hang expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: every port reads zero, no request, no error
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d); chk("R1 reset read", d, 8'h00);
        end
        chk("R1 int_req", {7'b0, int_req}, 8'h00);
        chk("R1 cmd_err", {7'b0, cmd_err}, 8'h00);
        wr(3'd1, 8'h55); rd(3'd1, d); chk("R1 mask write before init ignored", d, 8'h00);

        // R2 primary: word4 requested, cascade -> words 2,3,4
        wr(3'd0, 8'h11); wr(3'd1, 8'h40); wr(3'd1, 8'h04); wr(3'd1, 8'h01);
        // R2 secondary: single mode plus word4 -> words 2,4
        wr(3'd2, 8'h13); wr(3'd3, 8'h73); wr(3'd3, 8'h01);
        wr(3'd3, 8'hA5); rd(3'd3, d); chk("R2 secondary mask after single-mode init", d, 8'hA5);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h3C); rd(3'd1, d); chk("R2 primary mask readback", d, 8'h3C);
        wr(3'd1, 8'h00);
        // R3 select in-service view on both command ports
        wr(3'd0, 8'h0B); wr(3'd2, 8'h0B);

        // Sweep each line: R4, R5, R6, R9
        for (int l = 0; l < 16; l++) begin
            lines(16'(1) << l, '0);
            chk("R4 int_req single", {7'b0, int_req}, 8'h01);
            chk("R4 int_line single", {4'b0, int_line}, 8'(l));
            chk("R5 int_vec", int_vec, vexp(l));
            do_ack(l);
            rd(cmd_of(l), d); chk("R6 isr set", d, 8'(1) << (l % 8));
            chk("R6 edge request cleared", {7'b0, int_req}, 8'h00);
            wr(cmd_of(l), 8'(8'h60 | (l % 8)));
            rd(cmd_of(l), d); chk("R9 specific eoi", d, 8'h00);
        end

        // R4 every pair: lower index wins
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                lines((16'(1) << i) | (16'(1) << j), '0);
                chk("R4 pair winner", {4'b0, int_line}, 8'(i));
                lines('0, (16'(1) << i) | (16'(1) << j));
            end
        end
        chk("R12 lower clears", {7'b0, int_req}, 8'h00);

        // R4 masks: each masked line is not reported
        for (int l = 0; l < 16; l++) begin
            wr((l < 8) ? 3'd1 : 3'd3, 8'(1) << (l % 8));
            lines(16'(1) << l, '0);
            chk("R4 masked line hidden", {7'b0, int_req}, 8'h00);
            rd((l < 8) ? 3'd1 : 3'd3, d); chk("R2 mask read", d, 8'(1) << (l % 8));
            // R8 ack of a masked line does nothing
            do_ack(l);
            rd(cmd_of(l), d); chk("R8 stray ack isr", d, 8'h00);
            lines('0, 16'(1) << l);
            wr((l < 8) ? 3'd1 : 3'd3, 8'h00);
        end
        // R4 cascade gate
        wr(3'd1, 8'h04); lines(16'h0200, '0);
        chk("R4 secondary hidden by cascade mask", {7'b0, int_req}, 8'h00);
        wr(3'd1, 8'h00); #1;
        chk("R4 secondary via cascade", {4'b0, int_line}, 8'd9);
        lines('0, 16'h0200);
        // R12 raise wins over lower
        lines(16'h0010, 16'h0010);
        chk("R12 raise wins", {7'b0, int_req}, 8'h01);
        lines('0, 16'h0010);
        // R8 ack with nothing pending
        do_ack(5); rd(3'd0, d); chk("R8 idle ack", d, 8'h00);

        // R11 writable masks
        wr(3'd4, 8'hFF); rd(3'd4, d); chk("R11 primary ctl mask", d, 8'hF8);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R11 secondary ctl mask", d, 8'hDE);
        // R7 level line 3 keeps request through ack
        lines(16'h0008, '0); do_ack(3);
        chk("R7 level request kept", {7'b0, int_req}, 8'h01);
        chk("R7 level line", {4'b0, int_line}, 8'd3);
        rd(3'd0, d); chk("R7 isr set", d, 8'h08);
        lines('0, 16'h0008); wr(3'd0, 8'h63);
        // R11 line 0 is fixed edge
        lines(16'h0001, '0); do_ack(0);
        chk("R11 fixed edge line cleared", {7'b0, int_req}, 8'h00);
        wr(3'd0, 8'h60);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);

        // R9 non-specific eoi clears lowest
        lines(16'h0028, '0); do_ack(3); do_ack(5);
        rd(3'd0, d); chk("R9 two in service", d, 8'h28);
        wr(3'd0, 8'h20); rd(3'd0, d); chk("R9 nonspecific lowest", d, 8'h20);
        // R10 set-priority and no-op ignored
        wr(3'd0, 8'hC3); rd(3'd0, d); chk("R10 set priority ignored", d, 8'h20);
        wr(3'd0, 8'h40); rd(3'd0, d); chk("R10 no-op ignored", d, 8'h20);
        chk("R10 no error", {7'b0, cmd_err}, 8'h00);
        wr(3'd0, 8'h20); rd(3'd0, d); chk("R9 second nonspecific", d, 8'h00);

        // R3 read select
        wr(3'd0, 8'h0A); lines(16'h0040, '0);
        rd(3'd0, d); chk("R3 request view", d, 8'h40);
        wr(3'd0, 8'h08); rd(3'd0, d); chk("R3 select kept when bit1 clear", d, 8'h40);
        do_ack(6); rd(3'd0, d); chk("R3 request view after ack", d, 8'h00);
        wr(3'd0, 8'h66);

        // R10 unsupported command sets sticky flag
        wr(3'd2, 8'h00); #1;
        chk("R10 cmd_err set", {7'b0, cmd_err}, 8'h01);
        wr(3'd2, 8'h40); #1;
        chk("R10 cmd_err sticky", {7'b0, cmd_err}, 8'h01);

        // R2 word1 clears mask; mask loads only after sequence
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h10); rd(3'd1, d); chk("R2 word1 clears mask", d, 8'h00);
        wr(3'd1, 8'h80); wr(3'd1, 8'h04); wr(3'd1, 8'h12);
        rd(3'd1, d); chk("R2 mask after re-init", d, 8'h12);
        lines(16'h0001, '0);
        chk("R5 new base", int_vec, 8'h80);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule